// File: doc/BRIEF.md
# Asynchronous SRAM sequencer

This block sits between a simple single-beat host request port and an external asynchronous static RAM of 128K bytes. A host raises `req` for one cycle with `wr`, `addr` and `wdata`. The block then drives the memory's select pair, output enable, write enable, address and split data bus through one complete access, and pulses `done` when the access finishes. For reads, the captured byte appears on `rdata` in the same cycle as `done`.

Every analog timing limit of the memory is met by counting system clock cycles. The clock period `CLK_NS` and the speed grade `SPEED_NS` (70 or 100) are parameters. Each nanosecond limit is rounded up to whole clock cycles: `ceil(limit / CLK_NS)`. The sequencer keeps the address and select stable for the whole of an access. Its own data drivers stay off while the memory may still be driving the bus.

Top module: `asram_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, the memory is deselected (`mem_cs_n`=1, `mem_cs`=0), `mem_oe_n`=1, `mem_we_n`=1, `dq_oe`=0, `busy`=0 and `done`=0.
- R2: The memory counts as selected only when `mem_cs_n`=0 and `mem_cs`=1. The two lines always change together: both asserted for the duration of an access, both released otherwise. Output enable or write enable is only asserted while the memory is selected.
- R3: A read (`wr`=0) holds `mem_oe_n`=0 and `mem_we_n`=1 for ceil(tRC/CLK_NS) consecutive cycles, where tRC is 70 ns for grade 70 and 100 ns for grade 100. `mem_dq_i` is captured at the end of the last of these cycles and returned on `rdata`.
- R4: A write (`wr`=1) holds `mem_we_n`=0 and `mem_oe_n`=1 for ceil(max(write pulse, select-to-end, address-to-end, data setup)/CLK_NS) cycles. Those limits are 55/60/60/30 ns for grade 70 and 70/80/80/40 ns for grade 100. `mem_dq_o` carries `wdata` with `dq_oe`=1 for the whole pulse, and `mem_addr` does not change while `mem_we_n` is low.
- R5: From the start of a write to the start of the next access, at least ceil(tWC/CLK_NS) cycles pass, with tWC equal to tRC.
- R6: `dq_oe` is never 1 while `mem_oe_n` is 0. After a read, at least ceil(tHZ/CLK_NS) cycles pass after `mem_oe_n` rises before `dq_oe` can rise. tHZ is 25 ns for grade 70 and 30 ns for grade 100.
- R7: `done` is a single-cycle pulse, one per completed access. With `req` sampled at edge E0, `done` is high right after edge E0+N, where N is the read or write pulse length in cycles.
- R8: `busy` is high from acceptance until the float or recovery wait ends. A `req` sampled while `busy` is high starts no access and produces no `done`.
- R9: With `SPEED_NS`=100, the read and write pulse lengths follow the grade 100 limits of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request strobe, sampled while idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Last read data |
| busy | output | 1 | Access or bus wait in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_cs_n | output | 1 | Active-low memory select |
| mem_cs | output | 1 | Active-high memory select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | 17 | Memory address |
| mem_dq_o | output | 8 | Data toward memory |
| dq_oe | output | 1 | Enables the data pad driver |
| mem_dq_i | input | 8 | Data from memory |

## Verification
The bench runs a mix of writes and reads against a small byte-wide memory model in the bench. The addresses include zero, the top address and a rewritten location. Reading back distinct bytes tells a correct write pulse apart from a dropped or misaddressed one. Rewriting one location shows that the later write overwrites the earlier value.

A read placed right after a write, and a write right after a read, exercise the recovery and bus-float spacing. Pulse lengths and request-to-done latency are measured separately, so a miscounted limit is distinguished from a wrong capture cycle. A request held through a busy write, and a second instance at the slower grade, check that requests are ignored while busy and that the grade switch takes effect.

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq #(
  parameter int CLK_NS   = 10,
  parameter int SPEED_NS = 70,
  parameter int AW       = 17,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          busy,
  output logic          done,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  localparam bit FAST  = SPEED_NS <= 70;
  localparam int T_CYC = FAST ? 70 : 100;
  localparam int T_WP  = FAST ? 55 : 70;
  localparam int T_CW  = FAST ? 60 : 80;
  localparam int T_AW  = FAST ? 60 : 80;
  localparam int T_DS  = FAST ? 30 : 40;
  localparam int T_HZ  = FAST ? 25 : 30;
  localparam int T_W1  = T_WP > T_CW ? T_WP : T_CW;
  localparam int T_W2  = T_AW > T_DS ? T_AW : T_DS;
  localparam int T_WE  = T_W1 > T_W2 ? T_W1 : T_W2;
  localparam int RD_N  = (T_CYC + CLK_NS - 1) / CLK_NS;
  localparam int WE_N  = (T_WE + CLK_NS - 1) / CLK_NS;
  localparam int HZ_N  = (T_HZ + CLK_NS - 1) / CLK_NS;
  localparam int REC_N = RD_N > WE_N ? RD_N - WE_N : 0;
  localparam int MAXN  = RD_N > WE_N ? RD_N : WE_N;
  localparam int CW    = $clog2(MAXN + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_FLT, S_WR, S_REC} st_t;
  st_t st;
  logic [CW-1:0] cnt;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      mem_cs_n <= 1'b1;
      mem_cs   <= 1'b0;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      dq_oe    <= 1'b0;
      done     <= 1'b0;
      mem_addr <= '0;
      mem_dq_o <= '0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          mem_addr <= addr;
          mem_cs_n <= 1'b0;
          mem_cs   <= 1'b1;
          if (wr) begin
            mem_we_n <= 1'b0;
            dq_oe    <= 1'b1;
            mem_dq_o <= wdata;
            cnt      <= CW'(WE_N - 1);
            st       <= S_WR;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CW'(RD_N - 1);
            st       <= S_RD;
          end
        end
        S_RD: if (cnt == '0) begin
          rdata    <= mem_dq_i;
          mem_oe_n <= 1'b1;
          mem_cs_n <= 1'b1;
          mem_cs   <= 1'b0;
          done     <= 1'b1;
          cnt      <= CW'(HZ_N - 1);
          st       <= S_FLT;
        end else cnt <= cnt - 1'b1;
        S_WR: if (cnt == '0) begin
          mem_we_n <= 1'b1;
          dq_oe    <= 1'b0;
          mem_cs_n <= 1'b1;
          mem_cs   <= 1'b0;
          done     <= 1'b1;
          if (REC_N == 0) st <= S_IDLE;
          else begin
            cnt <= CW'(REC_N - 1);
            st  <= S_REC;
          end
        end else cnt <= cnt - 1'b1;
        S_FLT, S_REC: if (cnt == '0) st <= S_IDLE;
                      else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module asram_seq_chk #(parameter int AW = 17) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          mem_cs_n,
  input logic          mem_cs,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic          dq_oe
);
  assert_rst_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !dq_oe && !done));
  assert_sel_pair_R2: assert property (@(posedge clk) disable iff (rst)
    mem_cs_n == !mem_cs);
  assert_strobe_sel_R2: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n) |-> (!mem_cs_n && mem_cs));
  assert_we_drive_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (dq_oe && mem_oe_n));
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
  assert_no_contend_R6: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe && !mem_oe_n));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind asram_seq asram_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .done(done), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr), .dq_oe(dq_oe));

// File: tb/asram_seq_tb.sv
`timescale 1ns/1ps
module asram_seq_tb;
  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic req = 0, wr = 0;
  logic [16:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, mem_dq_o, mem_dq_i;
  logic busy, done, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, dq_oe;
  logic [16:0] mem_addr;

  asram_seq #(.CLK_NS(5), .SPEED_NS(70)) u_dut (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .done(done), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .dq_oe(dq_oe), .mem_dq_i(mem_dq_i));

  logic s_req = 0, s_wr = 0;
  logic [7:0] s_rdata, s_dq_o;
  logic s_busy, s_done, s_cs_n, s_cs, s_oe_n, s_we_n, s_dq_oe;
  logic [16:0] s_addr;
  asram_seq #(.CLK_NS(5), .SPEED_NS(100)) u_slow (
    .clk(clk), .rst(rst), .req(s_req), .wr(s_wr), .addr(17'h00123), .wdata(8'hC3),
    .rdata(s_rdata), .busy(s_busy), .done(s_done), .mem_cs_n(s_cs_n), .mem_cs(s_cs),
    .mem_oe_n(s_oe_n), .mem_we_n(s_we_n), .mem_addr(s_addr),
    .mem_dq_o(s_dq_o), .dq_oe(s_dq_oe), .mem_dq_i(8'h5A));

  int checks = 0, fails = 0;
  logic [7:0] mem [64];
  assign mem_dq_i = (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n) ? mem[mem_addr[5:0]] : 8'h00;

  int oe_run = 0, oe_last = 0, we_run = 0, we_last = 0, gap = 100, gap_bad = 0;
  int addr_bad = 0, since = 100, wc_bad = 0, starts = 0, dones = 0;
  int s_oe_run = 0, s_oe_last = 0, s_we_run = 0, s_we_last = 0;
  bit last_wr = 0, prev_cs_n = 1, pend = 0;
  logic [5:0] paddr;
  logic [7:0] pdata;
  logic [16:0] we_addr;

  always @(negedge clk) begin
    if (!mem_oe_n) oe_run++; else if (oe_run != 0) begin oe_last = oe_run; oe_run = 0; end
    if (!mem_we_n) begin
      if (we_run == 0) we_addr = mem_addr; else if (mem_addr != we_addr) addr_bad++;
      we_run++;
    end else if (we_run != 0) begin we_last = we_run; we_run = 0; end
    if (!mem_oe_n) gap = 0; else if (gap < 100) gap++;
    if (dq_oe && gap < 5) gap_bad++;
    if (!mem_cs_n && prev_cs_n) begin
      if (last_wr && since < 14) wc_bad++;
      starts++; since = 1; last_wr = !mem_we_n;
    end else if (since < 100) since++;
    prev_cs_n = mem_cs_n;
    if (!mem_cs_n && mem_cs && !mem_we_n && dq_oe) begin pend = 1; paddr = mem_addr[5:0]; pdata = mem_dq_o; end
    else if (pend) begin mem[paddr] = pdata; pend = 0; end
    if (done) dones++;
    if (!s_oe_n) s_oe_run++; else if (s_oe_run != 0) begin s_oe_last = s_oe_run; s_oe_run = 0; end
    if (!s_we_n) s_we_run++; else if (s_we_run != 0) begin s_we_last = s_we_run; s_we_run = 0; end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", r, act, exp); end
  endtask

  task automatic do_op(input bit w, input logic [16:0] a, input logic [7:0] d, output int lat);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d;
    @(negedge clk); req = 0; lat = 1;
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
  endtask

  // {wr, addr, wdata, expected read}
  localparam logic [33:0] VEC [8] = '{
    {1'b1, 17'h00010, 8'hA5, 8'h00}, {1'b1, 17'h1FFFF, 8'h3C, 8'h00},
    {1'b1, 17'h00000, 8'hFF, 8'h00}, {1'b0, 17'h00010, 8'h00, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h00, 8'h3C}, {1'b1, 17'h00010, 8'h00, 8'h00},
    {1'b0, 17'h00010, 8'h00, 8'h00}, {1'b0, 17'h00000, 8'h00, 8'hFF}};

  initial begin
    #750000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat, s0, d0;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !dq_oe, "R1 reset lines",
        {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, dq_oe}, 5'b10110);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    rst = 0;
    @(negedge clk);
    chk(mem_cs_n && !mem_cs && !busy, "R2 idle deselected", {mem_cs_n, mem_cs}, 2'b10);

    for (int i = 0; i < 8; i++) begin
      do_op(VEC[i][33], VEC[i][32:16], VEC[i][15:8], lat);
      repeat (2) @(negedge clk);
      if (VEC[i][33]) begin
        chk(lat == 13, "R7 write latency", lat, 13);
        chk(we_last == 12, "R4 write pulse", we_last, 12);
      end else begin
        chk(lat == 15, "R7 read latency", lat, 15);
        chk(oe_last == 14, "R3 read pulse", oe_last, 14);
        chk(rdata == VEC[i][7:0], "R3 read data", rdata, VEC[i][7:0]);
      end
    end
    chk(mem[16] == 8'h00 && mem[63] == 8'h3C && mem[0] == 8'hFF, "R4 model contents",
        mem[63], 8'h3C);

    do_op(1'b1, 17'h00020, 8'h5C, lat);
    do_op(1'b0, 17'h00020, 8'h00, lat);
    chk(rdata == 8'h5C, "R5 read right after write", rdata, 8'h5C);
    do_op(1'b1, 17'h00021, 8'h6D, lat);
    repeat (2) @(negedge clk);
    chk(mem[33] == 8'h6D, "R6 write right after read", mem[33], 8'h6D);
    chk(gap_bad == 0, "R6 bus float spacing", gap_bad, 0);
    chk(addr_bad == 0, "R4 address stable", addr_bad, 0);
    chk(wc_bad == 0, "R5 write cycle spacing", wc_bad, 0);

    @(negedge clk);
    s0 = starts; d0 = dones;
    req = 1; wr = 1; addr = 17'h00030; wdata = 8'h77;
    @(negedge clk); wr = 0; addr = 17'h1FFFF;
    chk(busy, "R8 busy after accept", busy, 1);
    repeat (4) @(negedge clk);
    req = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(starts == s0 + 1, "R8 request while busy ignored", starts - s0, 1);
    chk(dones == d0 + 1, "R7 one done per access", dones - d0, 1);
    chk(mem[48] == 8'h77, "R8 accepted write landed", mem[48], 8'h77);

    @(negedge clk); s_req = 1; s_wr = 0;
    @(negedge clk); s_req = 0;
    while (!s_done) @(negedge clk);
    chk(s_rdata == 8'h5A, "R9 slow grade read data", s_rdata, 8'h5A);
    repeat (2) @(negedge clk);
    chk(s_oe_last == 20, "R9 slow grade read pulse", s_oe_last, 20);
    while (s_busy) @(negedge clk);
    @(negedge clk); s_req = 1; s_wr = 1;
    @(negedge clk); s_req = 0;
    while (!s_done) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(s_we_last == 16, "R9 slow grade write pulse", s_we_last, 16);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule